// File: doc/BRIEF.md
# Four-bit ALU slice with group carry lookahead outputs

This block is one slice of a wider arithmetic logic unit. It takes two operands of `WIDTH` bits (four by default), a carry input and a three-bit operation code. It returns a result word together with active-low group generate and group propagate flags. An external carry-lookahead unit uses those flags to join several slices into a longer word. The slice offers eight operations:

- addition;
- subtraction in both directions;
- three bitwise logic operations;
- a forced all-zero result;
- a forced all-one result.

Operands and results are active high. For a true two's-complement difference in either subtract mode, the carry input of the least significant slice must be held at 1. With the carry input at 0, the difference comes out one lower.

All outputs are registered. They change on the rising clock edge that follows a change on the inputs. A synchronous active-high reset loads the idle values: result zero, and both lookahead flags high (inactive).

Top module: `alu_slice_la`

## Requirements
- R1: With `op_sel` = 3'b011 (`op_sel[0]` and `op_sel[1]` set), the result is `a_in + b_in + cin` modulo 2^WIDTH.
- R2: With `op_sel` = 3'b001, the result is `b_in + ~a_in + cin` modulo 2^WIDTH, which is b minus a when `cin` = 1 and one less than that when `cin` = 0.
- R3: With `op_sel` = 3'b010, the result is `a_in + ~b_in + cin` modulo 2^WIDTH, which is a minus b when `cin` = 1.
- R4: `op_sel` 3'b100 gives a XOR b, 3'b101 gives a OR b, and 3'b110 gives a AND b. In these three codes `cin` has no effect on any output.
- R5: `op_sel` = 3'b000 forces the result to all zeros, whatever the values of a, b and cin.
- R6: `op_sel` = 3'b111 forces the result to all ones, whatever the values of a, b and cin.
- R7: In the three arithmetic codes, let X and Y be the effective operands, with the complemented operand used when subtracting. `g_n` is low exactly when X + Y with zero carry-in produces a carry out of the top bit.
- R8: In the three arithmetic codes, `p_n` is low exactly when X_i | Y_i is 1 for every bit i.
- R9: In the clear, preset and logic codes, `g_n` and `p_n` are both 1.
- R10: Outputs change only on a rising clock edge and reflect the inputs sampled at that edge. While `rst` is 1 at an edge, the outputs become result 0, `g_n` = 1 and `p_n` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code |
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| cin | input | 1 | Carry into the least significant bit |
| f_out | output | WIDTH | Registered result |
| g_n | output | 1 | Registered group generate, active low |
| p_n | output | 1 | Registered group propagate, active low |

## Verification
The hardest condition to reach is a group generate that is produced only through the full propagate chain: every bit propagates and only the lowest bit generates. This must also occur in the subtract modes, where the operand complement changes which bits generate. The bench reaches it by sweeping every operand pair, both carry values and every operation code. The directed vectors also pin down specific cases: an all-ones plus one sum, a subtraction of equal operands with carry 0, and a reset asserted while a non-zero sum is being presented.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    OP_CLR   = 3'b000,
    OP_BSUBA = 3'b001,
    OP_ASUBB = 3'b010,
    OP_ADD   = 3'b011,
    OP_XOR   = 3'b100,
    OP_OR    = 3'b101,
    OP_AND   = 3'b110,
    OP_SET   = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    RES_ZERO,
    RES_ONES,
    RES_SUM,
    RES_XOR,
    RES_OR,
    RES_AND
  } res_src_e;

  typedef struct packed {
    logic     inv_a;
    logic     inv_b;
    logic     arith;
    res_src_e src;
  } op_ctrl_t;

endpackage

// File: rtl/alu_slice_dec.sv
module alu_slice_dec
  import alu_slice_pkg::*;
(
  input  logic [2:0] op_sel,
  output op_ctrl_t   ctrl
);

  always_comb begin
    ctrl = '{inv_a: 1'b0, inv_b: 1'b0, arith: 1'b0, src: RES_ZERO};
    unique case (alu_op_e'(op_sel))
      OP_CLR:   ctrl.src = RES_ZERO;
      OP_BSUBA: begin ctrl.inv_a = 1'b1; ctrl.arith = 1'b1; ctrl.src = RES_SUM; end
      OP_ASUBB: begin ctrl.inv_b = 1'b1; ctrl.arith = 1'b1; ctrl.src = RES_SUM; end
      OP_ADD:   begin ctrl.arith = 1'b1; ctrl.src = RES_SUM; end
      OP_XOR:   ctrl.src = RES_XOR;
      OP_OR:    ctrl.src = RES_OR;
      OP_AND:   ctrl.src = RES_AND;
      OP_SET:   ctrl.src = RES_ONES;
      default:  ctrl.src = RES_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_slice_arith.sv
module alu_slice_arith #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             grp_gen,
  output logic             grp_prop
);

  logic [WIDTH-1:0] gen_b, prop_b;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] g_acc, p_acc;

  assign gen_b  = x & y;
  assign prop_b = x | y;
  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign carry[i+1] = gen_b[i] | (prop_b[i] & carry[i]);
      assign sum[i]     = x[i] ^ y[i] ^ carry[i];
      if (i == 0) begin : g_first
        assign g_acc[i] = gen_b[i];
        assign p_acc[i] = prop_b[i];
      end else begin : g_next
        assign g_acc[i] = gen_b[i] | (prop_b[i] & g_acc[i-1]);
        assign p_acc[i] = prop_b[i] & p_acc[i-1];
      end
    end
  endgenerate

  assign grp_gen  = g_acc[WIDTH-1];
  assign grp_prop = p_acc[WIDTH-1];

endmodule

// File: rtl/alu_slice_logic.sv
module alu_slice_logic
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  res_src_e         src,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    unique case (src)
      RES_ZERO: res = '0;
      RES_ONES: res = '1;
      RES_SUM:  res = sum;
      RES_XOR:  res = a ^ b;
      RES_OR:   res = a | b;
      RES_AND:  res = a & b;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/alu_slice_la.sv
module alu_slice_la
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cin,
  output logic [WIDTH-1:0] f_out,
  output logic             g_n,
  output logic             p_n
);

  op_ctrl_t         ctrl;
  logic [WIDTH-1:0] x_eff, y_eff, sum, res;
  logic             grp_gen, grp_prop;

  alu_slice_dec u_dec (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  assign x_eff = ctrl.inv_a ? ~a_in : a_in;
  assign y_eff = ctrl.inv_b ? ~b_in : b_in;

  alu_slice_arith #(.WIDTH(WIDTH)) u_arith (
    .x        (x_eff),
    .y        (y_eff),
    .cin      (cin),
    .sum      (sum),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  alu_slice_logic #(.WIDTH(WIDTH)) u_logic (
    .src (ctrl.src),
    .a   (a_in),
    .b   (b_in),
    .sum (sum),
    .res (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_out <= '0;
      g_n   <= 1'b1;
      p_n   <= 1'b1;
    end else begin
      f_out <= res;
      g_n   <= ~(ctrl.arith & grp_gen);
      p_n   <= ~(ctrl.arith & grp_prop);
    end
  end

endmodule

// File: rtl/alu_slice_la_chk.sv
module alu_slice_la_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             cin,
  input logic [WIDTH-1:0] f_out,
  input logic             g_n,
  input logic             p_n
);

  logic             is_arith;
  logic [WIDTH-1:0] xm, ym;
  logic [WIDTH:0]   wide_sum;

  assign is_arith = (op_sel != 3'b000) && !op_sel[2];
  assign xm = (op_sel == 3'b001) ? ~a_in : a_in;
  assign ym = (op_sel == 3'b010) ? ~b_in : b_in;
  assign wide_sum = {1'b0, xm} + {1'b0, ym};

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b011) |=> (f_out == ($past(a_in) + $past(b_in) + WIDTH'($past(cin)))));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b000) |=> (f_out == '0));

  // R6
  preset_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b111) |=> (f_out == '1));

  // R4
  xor_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b100) |=> (f_out == ($past(a_in) ^ $past(b_in))));

  // R9
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !is_arith |=> (g_n && p_n));

  // R7
  group_gen_chk: assert property (@(posedge clk) disable iff (rst)
    is_arith |=> (g_n == !$past(wide_sum[WIDTH])));

  // R8
  group_prop_chk: assert property (@(posedge clk) disable iff (rst)
    is_arith |=> (p_n == !(&$past(xm | ym))));

  // R10
  reset_values_chk: assert property (@(posedge clk)
    rst |=> (f_out == '0 && g_n && p_n));

endmodule

bind alu_slice_la alu_slice_la_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_alu_slice_la.sv
module tb_alu_slice_la;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NVEC = 10;

  // {op, a, b, cin, f, g_n, p_n}
  localparam logic [17:0] VEC [NVEC] = '{
    {3'b011, 4'h3, 4'h5, 1'b0, 4'h8, 1'b1, 1'b1},
    {3'b011, 4'hF, 4'h1, 1'b0, 4'h0, 1'b0, 1'b0},
    {3'b001, 4'h3, 4'h5, 1'b1, 4'h2, 1'b0, 1'b1},
    {3'b010, 4'h3, 4'h5, 1'b1, 4'hE, 1'b1, 1'b1},
    {3'b010, 4'h7, 4'h7, 1'b0, 4'hF, 1'b1, 1'b0},
    {3'b100, 4'hC, 4'hA, 1'b1, 4'h6, 1'b1, 1'b1},
    {3'b101, 4'hC, 4'hA, 1'b1, 4'hE, 1'b1, 1'b1},
    {3'b110, 4'hC, 4'hA, 1'b0, 4'h8, 1'b1, 1'b1},
    {3'b000, 4'hF, 4'hF, 1'b1, 4'h0, 1'b1, 1'b1},
    {3'b111, 4'h0, 4'h0, 1'b0, 4'hF, 1'b1, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_sel = 3'b011;
  logic [W-1:0] a_in = 4'h9;
  logic [W-1:0] b_in = 4'h4;
  logic         cin = 1'b1;
  logic [W-1:0] f_out;
  logic         g_n, p_n;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_slice_la #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .a_in(a_in), .b_in(b_in),
    .cin(cin), .f_out(f_out), .g_n(g_n), .p_n(p_n)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b011:  return "R1/R7/R8";
      3'b001:  return "R2/R7/R8";
      3'b010:  return "R3/R7/R8";
      3'b000:  return "R5/R9";
      3'b111:  return "R6/R9";
      default: return "R4/R9";
    endcase
  endfunction

  task automatic model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, output logic [W-1:0] f, output logic g, output logic p);
    logic [W-1:0] x, y;
    logic [W:0]   s0;
    x = (op == 3'b001) ? ~a : a;
    y = (op == 3'b010) ? ~b : b;
    s0 = {1'b0, x} + {1'b0, y};
    g = 1'b1; p = 1'b1;
    case (op)
      3'b000: f = '0;
      3'b111: f = '1;
      3'b100: f = a ^ b;
      3'b101: f = a | b;
      3'b110: f = a & b;
      default: begin
        f = W'(x + y + W'(c));
        g = ~s0[W];
        p = ~(&(x | y));
      end
    endcase
  endtask

  task automatic check(input string tag, input logic [W-1:0] ef, input logic eg, input logic ep);
    n_chk++;
    if (f_out !== ef || g_n !== eg || p_n !== ep) begin
      n_bad++;
      $display("FAIL %s: got f=%h g_n=%b p_n=%b, expected f=%h g_n=%b p_n=%b",
               tag, f_out, g_n, p_n, ef, eg, ep);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(negedge clk);
    op_sel = op; a_in = a; b_in = b; cin = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] ef;
    logic eg, ep;
    // R10: reset state while a non-zero sum is presented
    @(posedge clk);
    @(negedge clk);
    check("R10 reset state", '0, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    // table of directed vectors
    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][17:15], VEC[k][14:11], VEC[k][10:7], VEC[k][6]);
      check($sformatf("%s table[%0d]", req_of(VEC[k][17:15]), k),
            VEC[k][5:2], VEC[k][1], VEC[k][0]);
    end

    // R4: cin has no effect in the logic codes
    for (int op = 4; op < 7; op++) begin
      apply(3'(op), 4'h6, 4'h3, 1'b0);
      model(3'(op), 4'h6, 4'h3, 1'b0, ef, eg, ep);
      check("R4 logic cin=0", ef, eg, ep);
      apply(3'(op), 4'h6, 4'h3, 1'b1);
      check("R4 logic cin=1", ef, eg, ep);
    end

    // exhaustive sweep
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            apply(3'(op), 4'(a), 4'(b), 1'(c));
            model(3'(op), 4'(a), 4'(b), 1'(c), ef, eg, ep);
            check(req_of(3'(op)), ef, eg, ep);
          end

    // R10: mid-run reset overrides a live sum, then the value follows one edge later
    apply(3'b011, 4'hF, 4'h1, 1'b1);
    check("R10 pre-reset sum", 4'h1, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 mid-run reset", '0, 1'b1, 1'b1);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 after reset release", 4'h1, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule